// File: doc/BRIEF.md
# Conditional Stream Cluster Compactor

This block sits between a stream buffer and a four-lane SIMD cluster array. It accepts a group of four words (one word for each cluster position) together with a condition mask that says which clusters are powered. It then hands the words out only to the powered clusters, in order, over as many successive accesses as needed. When the array is halved or quartered, a full-width stream is consumed by the remaining clusters and no word is lost.

The mask is taken once per group, at the moment the group is accepted. While a group is still being handed out, the input handshake is held off. Clusters outside the mask receive nothing, and a gate-off flag tells the power controller that it may switch them off entirely. A mask outside the supported reductions is refused. An error pulse reports the refusal, and the group is delivered under the mask that was already in force.

Top module: `cond_stream_compactor`

## Requirements
- R1: After reset, inReady is 1, outValid is all zero, maskErr is 0 and gateOff is all zero, meaning the full mask 4'b1111 is in force.
- R2: Bit i of maskReq selects cluster i. Only three masks are legal: 4'b1111 (all clusters), 4'b0011 (clusters 0 and 1) and 4'b0001 (cluster 0).
- R3: With mask 4'b1111, one access in the cycle after acceptance delivers word i of the group (inData bits 16*i+15 to 16*i) to cluster i.
- R4: With mask 4'b0011, the first access delivers words 0 and 1 to clusters 0 and 1, and the next cycle's access delivers words 2 and 3 to the same clusters.
- R5: With mask 4'b0001, four consecutive accesses deliver words 0, 1, 2 and 3 to cluster 0.
- R6: A cluster outside the applied mask never has its outValid bit set, and its outData lane reads zero.
- R7: gateOff is the bitwise complement of the applied mask. It changes only in the cycle after a group is accepted.
- R8: inReady is 0 during every access of a group except the last. It is 1 during the last access and when idle. A group accepted during a last access starts delivery in the very next cycle.
- R9: A group accepted with an illegal mask is delivered under the previous mask. maskErr is 1 for exactly the one cycle after that acceptance.
- R10: Changing maskReq while a group is being delivered has no effect on that group. The new value applies to the next group accepted.
- R11: With no group pending, outValid stays all zero.
- R12: A synchronous reset in the middle of a group abandons the group and restores the R1 state.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A four-word group is offered |
| inReady | output | 1 | The block will take the offered group on this edge |
| inData | input | 64 | Group words, word i in bits 16*i+15 to 16*i |
| maskReq | input | 4 | Requested cluster condition mask, sampled at acceptance |
| outValid | output | 4 | Per-cluster word-present flag for this access |
| outData | output | 64 | Per-cluster word, lane i in bits 16*i+15 to 16*i |
| gateOff | output | 4 | Per-cluster power-off permission (complement of the applied mask) |
| maskErr | output | 1 | One-cycle pulse after a group is accepted with an illegal mask |

## Verification
The checker watches several properties on every cycle. It checks that valid lanes never overlap gated lanes, that the valid lanes form the applied-mask prefix, and that the applied mask is always one of the three legal shapes. It also checks that gateOff and the error pulse move only right after an acceptance, and that input stalls happen only while a group is being delivered. The word order across accesses, the number of accesses for each reduction and the fallback to the previous mask cannot be seen by a property. The bench shows them by comparing each lane against words it computes from the group it sent. Back-to-back acceptance at the last access, a mask change in the middle of a group and a reset in the middle of a group are covered by directed bench scenarios.

// File: rtl/csc_pkg.sv
package csc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture the offered group this edge
    logic show;  // a group is being delivered this cycle
  } cscStrobe_t;
endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
#(
  parameter int NUM_CL = 4,
  localparam int LG = $clog2(NUM_CL),
  localparam int LGW = $clog2(LG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [NUM_CL-1:0] maskReq,
  output logic              inReady,
  output cscStrobe_t        strobe,
  output logic [LG-1:0]     beat,
  output logic [LGW-1:0]    curLg,
  output logic [NUM_CL-1:0] curMask,
  output logic              maskErr
);
  localparam logic [NUM_CL-1:0] FULL = {NUM_CL{1'b1}};

  // legal masks are low prefixes whose size is a power of two
  function automatic logic isLegal(input logic [NUM_CL-1:0] m);
    logic ok;
    ok = 1'b0;
    for (int k = 0; k <= LG; k++)
      if (m == (FULL >> (NUM_CL - (1 << k)))) ok = 1'b1;
    return ok;
  endfunction

  function automatic logic [LGW-1:0] lgOf(input logic [NUM_CL-1:0] m);
    logic [LGW-1:0] r;
    r = '0;
    for (int k = 0; k <= LG; k++)
      if (m == (FULL >> (NUM_CL - (1 << k)))) r = LGW'(k);
    return r;
  endfunction

  logic busy;
  logic lastBeat;
  logic accept;
  logic [LG-1:0] beatsMinus1;

  assign beatsMinus1 = LG'((NUM_CL >> curLg) - 1);
  assign lastBeat    = busy && (beat == beatsMinus1);
  assign inReady     = !busy || lastBeat;
  assign accept      = inValid && inReady;

  always_comb begin
    strobe.load = accept;
    strobe.show = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      beat    <= '0;
      curMask <= FULL;
      curLg   <= LGW'(LG);
      maskErr <= 1'b0;
    end else begin
      maskErr <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        beat <= '0;
        if (isLegal(maskReq)) begin
          curMask <= maskReq;
          curLg   <= lgOf(maskReq);
        end else begin
          maskErr <= 1'b1;
        end
      end else if (lastBeat) begin
        busy <= 1'b0;
        beat <= '0;
      end else if (busy) begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int NUM_CL = 4,
  parameter int W = 16,
  localparam int LG = $clog2(NUM_CL),
  localparam int LGW = $clog2(LG + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  cscStrobe_t          strobe,
  input  logic [LG-1:0]       beat,
  input  logic [LGW-1:0]      curLg,
  input  logic [NUM_CL-1:0]   curMask,
  input  logic [NUM_CL*W-1:0] inData,
  output logic [NUM_CL-1:0]   outValid,
  output logic [NUM_CL*W-1:0] outData
);
  logic [W-1:0] grpWord [NUM_CL];

  for (genvar g = 0; g < NUM_CL; g++) begin : gCap
    always_ff @(posedge clk) begin
      if (rst) grpWord[g] <= '0;
      else if (strobe.load) grpWord[g] <= inData[g*W +: W];
    end
  end

  // lane i of access b carries word b*activeCount + i
  for (genvar i = 0; i < NUM_CL; i++) begin : gLane
    logic [LG-1:0] sel;
    logic laneOn;
    always_comb begin
      sel = (beat << curLg) + LG'(i);
      laneOn = strobe.show && curMask[i];
      outValid[i] = laneOn;
      outData[i*W +: W] = laneOn ? grpWord[sel] : '0;
    end
  end
endmodule

// File: rtl/cond_stream_compactor.sv
module cond_stream_compactor
  import csc_pkg::*;
#(
  parameter int NUM_CL = 4,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [NUM_CL*W-1:0] inData,
  input  logic [NUM_CL-1:0]   maskReq,
  output logic [NUM_CL-1:0]   outValid,
  output logic [NUM_CL*W-1:0] outData,
  output logic [NUM_CL-1:0]   gateOff,
  output logic                maskErr
);
  localparam int LG = $clog2(NUM_CL);
  localparam int LGW = $clog2(LG + 1);

  cscStrobe_t strobe;
  logic [LG-1:0] beat;
  logic [LGW-1:0] curLg;
  logic [NUM_CL-1:0] curMask;

  csc_ctrl #(.NUM_CL(NUM_CL)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .maskReq(maskReq),
    .inReady(inReady), .strobe(strobe), .beat(beat), .curLg(curLg),
    .curMask(curMask), .maskErr(maskErr)
  );

  csc_datapath #(.NUM_CL(NUM_CL), .W(W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .beat(beat), .curLg(curLg),
    .curMask(curMask), .inData(inData), .outValid(outValid), .outData(outData)
  );

  assign gateOff = ~curMask;
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int NUM_CL = 4,
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                inReady,
  input logic [NUM_CL*W-1:0] inData,
  input logic [NUM_CL-1:0]   maskReq,
  input logic [NUM_CL-1:0]   outValid,
  input logic [NUM_CL*W-1:0] outData,
  input logic [NUM_CL-1:0]   gateOff,
  input logic                maskErr
);
  // R6: a gated cluster never sees a valid word
  p_no_gated_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid & gateOff) == '0);

  // R6: valid lanes are either none or exactly the applied mask
  p_valid_prefix_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid == '0) || (outValid == ~gateOff));

  // R2: applied mask is a low prefix of power-of-two size
  p_mask_shape_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gateOff + 1'b1) && $onehot($countones(~gateOff)));

  // R7 R10: gating moves only after an acceptance
  p_gate_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid && inReady) |-> $stable(gateOff));

  // R9: error pulse only follows an acceptance
  p_err_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    maskErr |-> $past(inValid && inReady));

  // R8: input stalls only while a group is being delivered
  p_stall_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> (outValid != '0));

  // R8: a stalled cycle is followed by delivery continuing
  p_stall_next_r8: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> (outValid != '0));

  logic unusedSig;
  assign unusedSig = ^{inData, maskReq, outData};
endmodule

bind cond_stream_compactor csc_checker #(.NUM_CL(NUM_CL), .W(W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .inData(inData), .maskReq(maskReq), .outValid(outValid),
  .outData(outData), .gateOff(gateOff), .maskErr(maskErr)
);

// File: tb/sim_cond_stream_compactor.sv
`timescale 1ns/1ps
module sim_cond_stream_compactor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic [63:0] inData = '0;
  logic [3:0] maskReq = 4'b1111;
  logic [3:0] outValid;
  logic [63:0] outData;
  logic [3:0] gateOff;
  logic maskErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cond_stream_compactor u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inData(inData), .maskReq(maskReq), .outValid(outValid),
    .outData(outData), .gateOff(gateOff), .maskErr(maskErr)
  );

  // request mask, group, applied mask, expected error pulse
  localparam int NV = 8;
  localparam logic [3:0]  V_REQ [NV] = '{4'b1111, 4'b0011, 4'b0001, 4'b0011,
                                         4'b0101, 4'b1111, 4'b0001, 4'b1000};
  localparam logic [63:0] V_DAT [NV] = '{64'h4444_3333_2222_1111, 64'hDDDD_CCCC_BBBB_AAAA,
                                         64'h0F0F_0E0E_0D0D_0C0C, 64'h1234_5678_9ABC_DEF0,
                                         64'hA5A5_5A5A_FFFF_0001, 64'h0008_0007_0006_0005,
                                         64'hBEEF_CAFE_F00D_D00D, 64'h7777_6666_5555_4444};
  localparam logic [3:0]  V_APP [NV] = '{4'b1111, 4'b0011, 4'b0001, 4'b0011,
                                         4'b0011, 4'b1111, 4'b0001, 4'b0001};
  localparam logic        V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expLanes(input logic [63:0] d, input logic [3:0] m, input int b);
    logic [63:0] r;
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) n += m[i] ? 1 : 0;
    r = '0;
    for (int i = 0; i < 4; i++)
      if (m[i]) r[i*16 +: 16] = d[(b*n + i)*16 +: 16];
    return r;
  endfunction

  function automatic int beatsOf(input logic [3:0] m);
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) n += m[i] ? 1 : 0;
    return 4 / n;
  endfunction

  // check one access; tag names the requirement for this mask
  task automatic checkBeat(input string tag, input logic [63:0] d, input logic [3:0] m,
                           input int b, input int nb, input logic e);
    check(outValid == m, {tag, " R6 valid"}, 64'(outValid), 64'(m));
    check(outData == expLanes(d, m, b), {tag, " data"}, outData, expLanes(d, m, b));
    check(gateOff == ~m, "R7 gateOff", 64'(gateOff), 64'(~m));
    check(inReady == (b == nb - 1), "R8 ready", 64'(inReady), 64'(b == nb - 1));
    check(maskErr == ((b == 0) ? e : 1'b0), "R9 maskErr", 64'(maskErr), 64'((b == 0) ? e : 1'b0));
  endtask

  task automatic runGroup(input logic [3:0] req, input logic [63:0] d,
                          input logic [3:0] app, input logic e);
    int nb;
    string tag;
    nb = beatsOf(app);
    tag = (app == 4'b1111) ? "R3" : (app == 4'b0011) ? "R4" : "R5";
    @(negedge clk);
    inValid = 1'b1; maskReq = req; inData = d;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      checkBeat(tag, d, app, b, nb, e);
      if (b < nb - 1) @(negedge clk);
    end
    @(negedge clk);
    check(outValid == 4'b0000, "R11 idle", 64'(outValid), 64'h0);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(inReady == 1'b1, "R1 ready", 64'(inReady), 64'h1);
    check(outValid == 4'b0, "R1 valid", 64'(outValid), 64'h0);
    check(gateOff == 4'b0, "R1 gate", 64'(gateOff), 64'h0);
    check(maskErr == 1'b0, "R1 err", 64'(maskErr), 64'h0);
    // R11: idle with no offer
    repeat (3) @(negedge clk);
    check(outValid == 4'b0, "R11 no offer", 64'(outValid), 64'h0);

    // R2 R3 R4 R5 R9 table walk
    for (int v = 0; v < NV; v++) runGroup(V_REQ[v], V_DAT[v], V_APP[v], V_ERR[v]);

    // R10 R8: mask change mid-group, back-to-back acceptance at last access
    @(negedge clk);
    inValid = 1'b1; maskReq = 4'b0001; inData = 64'h0004_0003_0002_0001;
    @(negedge clk);
    maskReq = 4'b1111; inData = 64'h00D0_00C0_00B0_00A0;
    for (int b = 0; b < 4; b++) begin
      checkBeat("R10", 64'h0004_0003_0002_0001, 4'b0001, b, 4, 1'b0);
      if (b < 3) @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 4'b1111, "R8 back-to-back valid", 64'(outValid), 64'hF);
    check(outData == 64'h00D0_00C0_00B0_00A0, "R10 next group data", outData, 64'h00D0_00C0_00B0_00A0);
    check(gateOff == 4'b0000, "R10 next group gate", 64'(gateOff), 64'h0);
    @(negedge clk);
    check(outValid == 4'b0, "R11 idle after", 64'(outValid), 64'h0);

    // R12: reset in the middle of a quarter group
    inValid = 1'b1; maskReq = 4'b0001; inData = 64'h1111_2222_3333_4444;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check(inReady == 1'b0, "R12 busy before reset", 64'(inReady), 64'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(outValid == 4'b0, "R12 valid", 64'(outValid), 64'h0);
    check(gateOff == 4'b0, "R12 gate", 64'(gateOff), 64'h0);
    check(inReady == 1'b1, "R12 ready", 64'(inReady), 64'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule